// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port RAM

This block is a dual-port memory whose total capacity is fixed while each port sees it with a different shape. The wide port (port A) reads and writes whole words of `WIDTH_A` bits at `DEPTH_A` word addresses. The narrow port (port B) reads and writes words of `WIDTH_A / RATIO` bits at `DEPTH_A * RATIO` addresses. Width and depth therefore trade against each other. With the default `WIDTH_A = 36`, `DEPTH_A = 512`, a ratio of 2 gives port B 18 bits by 1024 words, and a ratio of 4 gives 9 bits by 2048 words.

A narrow address is a wide word address with a slice index below it. The low `log2(RATIO)` bits pick one slice of the wide word: slice 0 is the least-significant slice, and higher indices sit at higher bit positions. The remaining upper bits are the wide word address. A typical use packs data into wide words on port A and then drains it one narrow word per access on port B, or the reverse.

Both ports run on one shared clock and have their own enable, write enable, address and data buses. Reads are synchronous and return the old contents when the same port writes in that cycle (read-first). A reset clears only the read-data registers. The block has no sequencing state: each port does its work in the single cycle in which its enable is high.

Top module: `mixed_aspect_ram`

## Requirements
- R1: Port B is `WIDTH_A/RATIO` bits wide with `DEPTH_A*RATIO` addresses (address width `log2(DEPTH_A)+log2(RATIO)`). A `RATIO` other than 1, 2 or 4, a `WIDTH_A` not divisible by `RATIO`, or a `DEPTH_A` that is not a power of two stops elaboration.
- R2: A port A access with `a_en` high presents on `a_rdata`, after the next rising clock edge, the word stored at `a_addr` before that edge.
- R3: A port A write (`a_en` and `a_we` high) stores all `WIDTH_A` bits of `a_wdata` at `a_addr`. A later read of that word returns them.
- R4: The slice index is `b_addr[log2(RATIO)-1:0]` and the wide word address is `b_addr` shifted right by `log2(RATIO)`. Slice `s` is bits `[s*WB +: WB]` of the wide word, where WB is the port B width. `b_rdata` returns that slice one cycle after an enabled access.
- R5: A port B write replaces only its selected slice of the wide word. All other bits of that word stay unchanged.
- R6: Each port is read-first. In a write cycle its read data returns the contents that the address held before the write.
- R7: A write on either port is visible to a read on the other port in the following cycle.
- R8: When both ports write the same wide word in the same cycle, port B's slice receives `b_wdata` and the other slices receive the matching bits of `a_wdata`. The read data of both ports in that cycle is the old contents.
- R9: While a port's enable is low, its write enable is ignored (memory unchanged) and its read data holds its previous value.
- R10: With `rst_n` low at a rising edge, `a_rdata` and `b_rdata` become zero. Stored contents are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read-data registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable, qualified by a_en |
| a_addr | input | log2(DEPTH_A) | Port A word address |
| a_wdata | input | WIDTH_A | Port A write data |
| a_rdata | output | WIDTH_A | Port A read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable, qualified by b_en |
| b_addr | input | log2(DEPTH_A)+log2(RATIO) | Port B address: word address above slice index |
| b_wdata | input | WIDTH_A/RATIO | Port B write data |
| b_rdata | output | WIDTH_A/RATIO | Port B read data |

## Verification
The bench builds the block with `WIDTH_A = 8`, `DEPTH_A = 8` and `RATIO = 4`, giving port B 2-bit words at 32 addresses. At that size, every wide word and every narrow slice can be written and read back on both ports in sweeps of a few dozen cycles. The bench also checks the read-first value of each of those writes against a model it computes arithmetically. The four-way split makes every slice-index decode and every preserved-neighbour case reachable, including a same-word write collision and a disabled write with the enable low.

// File: rtl/mar_pkg.sv
package mar_pkg;

    // Number of slice-select bits for a supported width ratio.
    function automatic int unsigned sel_bits(input int unsigned ratio);
        return (ratio == 4) ? 2 : ((ratio == 2) ? 1 : 0);
    endfunction

    // Only power-of-two ratios up to four are supported.
    function automatic bit ratio_ok(input int unsigned ratio);
        return (ratio == 1) || (ratio == 2) || (ratio == 4);
    endfunction

endpackage

// File: rtl/mar_lane.sv
// One slice-wide column of the storage, addressed by wide word address.
// Port A and port B share the column; B's write lands after A's in the
// same cycle, so B wins a collision for this slice.
module mar_lane #(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANE_W-1:0] a_wdata,
    output logic [LANE_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANE_W-1:0] b_wdata,
    output logic [LANE_W-1:0] b_rdata
);

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            cells[a_addr] <= a_wdata;
        end
        if (b_en && b_we) begin
            cells[b_addr] <= b_wdata;
        end
    end

    // Read-first: nonblocking updates above leave the old value visible here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_en) begin
                a_rdata <= cells[a_addr];
            end
            if (b_en) begin
                b_rdata <= cells[b_addr];
            end
        end
    end

endmodule

// File: rtl/mar_b_decode.sv
// Splits the narrow address into word address and slice index and
// steers the narrow write enable to the selected column.
module mar_b_decode #(
    parameter int unsigned RATIO    = 2,
    parameter int unsigned SEL_W    = 1,
    parameter int unsigned SEL_WC   = 1,
    parameter int unsigned ADDR_A_W = 9,
    parameter int unsigned ADDR_B_W = 10
) (
    input  logic                b_we,
    input  logic [ADDR_B_W-1:0] b_addr,
    output logic [ADDR_A_W-1:0] word_addr,
    output logic [SEL_WC-1:0]   slice_sel,
    output logic [RATIO-1:0]    lane_we
);

    generate
        if (SEL_W == 0) begin : g_flat
            assign word_addr = b_addr[ADDR_A_W-1:0];
            assign slice_sel = '0;
        end else begin : g_split
            assign word_addr = b_addr[ADDR_B_W-1:SEL_W];
            assign slice_sel = b_addr[SEL_W-1:0];
        end
    endgenerate

    generate
        for (genvar i = 0; i < RATIO; i++) begin : g_we
            assign lane_we[i] = b_we && (slice_sel == SEL_WC'(i));
        end
    endgenerate

endmodule

// File: rtl/mar_b_mux.sv
// Remembers which slice the last enabled narrow access chose and
// selects that column's read register onto the narrow output.
module mar_b_mux #(
    parameter int unsigned RATIO  = 2,
    parameter int unsigned LANE_W = 18,
    parameter int unsigned SEL_WC = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    b_en,
    input  logic [SEL_WC-1:0]       slice_sel,
    input  logic [RATIO*LANE_W-1:0] lanes_rdata,
    output logic [LANE_W-1:0]       b_rdata
);

    logic [SEL_WC-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (b_en) begin
            sel_q <= slice_sel;
        end
    end

    always_comb begin
        b_rdata = lanes_rdata[int'(sel_q)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/mixed_aspect_ram.sv
module mixed_aspect_ram #(
    parameter int unsigned WIDTH_A  = 36,
    parameter int unsigned DEPTH_A  = 512,
    parameter int unsigned RATIO    = 2,
    localparam int unsigned WIDTH_B  = WIDTH_A / RATIO,
    localparam int unsigned SEL_W    = mar_pkg::sel_bits(RATIO),
    localparam int unsigned ADDR_A_W = $clog2(DEPTH_A),
    localparam int unsigned ADDR_B_W = ADDR_A_W + SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_en,
    input  logic                a_we,
    input  logic [ADDR_A_W-1:0] a_addr,
    input  logic [WIDTH_A-1:0]  a_wdata,
    output logic [WIDTH_A-1:0]  a_rdata,
    input  logic                b_en,
    input  logic                b_we,
    input  logic [ADDR_B_W-1:0] b_addr,
    input  logic [WIDTH_B-1:0]  b_wdata,
    output logic [WIDTH_B-1:0]  b_rdata
);

    localparam int unsigned SEL_WC = (SEL_W == 0) ? 1 : SEL_W;

    // Elaboration-time configuration checks.
    generate
        if (!mar_pkg::ratio_ok(RATIO)) begin : g_bad_ratio
            $error("mixed_aspect_ram: RATIO must be 1, 2 or 4");
        end
        if ((WIDTH_A % RATIO) != 0) begin : g_bad_width
            $error("mixed_aspect_ram: WIDTH_A must divide evenly by RATIO");
        end
        if ((1 << ADDR_A_W) != DEPTH_A) begin : g_bad_depth
            $error("mixed_aspect_ram: DEPTH_A must be a power of two");
        end
    endgenerate

    logic [ADDR_A_W-1:0]      b_word;
    logic [SEL_WC-1:0]        b_slice;
    logic [RATIO-1:0]         b_lane_we;
    logic [RATIO*WIDTH_B-1:0] b_lanes_rdata;

    mar_b_decode #(
        .RATIO    (RATIO),
        .SEL_W    (SEL_W),
        .SEL_WC   (SEL_WC),
        .ADDR_A_W (ADDR_A_W),
        .ADDR_B_W (ADDR_B_W)
    ) u_decode (
        .b_we      (b_we),
        .b_addr    (b_addr),
        .word_addr (b_word),
        .slice_sel (b_slice),
        .lane_we   (b_lane_we)
    );

    generate
        for (genvar i = 0; i < RATIO; i++) begin : g_lane
            mar_lane #(
                .LANE_W (WIDTH_B),
                .DEPTH  (DEPTH_A),
                .ADDR_W (ADDR_A_W)
            ) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .a_en    (a_en),
                .a_we    (a_we),
                .a_addr  (a_addr),
                .a_wdata (a_wdata[i*WIDTH_B +: WIDTH_B]),
                .a_rdata (a_rdata[i*WIDTH_B +: WIDTH_B]),
                .b_en    (b_en),
                .b_we    (b_lane_we[i]),
                .b_addr  (b_word),
                .b_wdata (b_wdata),
                .b_rdata (b_lanes_rdata[i*WIDTH_B +: WIDTH_B])
            );
        end
    endgenerate

    mar_b_mux #(
        .RATIO  (RATIO),
        .LANE_W (WIDTH_B),
        .SEL_WC (SEL_WC)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .b_en        (b_en),
        .slice_sel   (b_slice),
        .lanes_rdata (b_lanes_rdata),
        .b_rdata     (b_rdata)
    );

endmodule

// File: rtl/mar_checker.sv
module mar_checker #(
    parameter int unsigned WIDTH_A = 36,
    parameter int unsigned DEPTH_A = 512,
    parameter int unsigned RATIO   = 2
) (
    input logic                                                  clk,
    input logic                                                  rst_n,
    input logic                                                  a_en,
    input logic                                                  a_we,
    input logic [$clog2(DEPTH_A)-1:0]                            a_addr,
    input logic [WIDTH_A-1:0]                                    a_wdata,
    input logic [WIDTH_A-1:0]                                    a_rdata,
    input logic                                                  b_en,
    input logic                                                  b_we,
    input logic [$clog2(DEPTH_A)+mar_pkg::sel_bits(RATIO)-1:0]   b_addr,
    input logic [WIDTH_A/RATIO-1:0]                              b_wdata,
    input logic [WIDTH_A/RATIO-1:0]                              b_rdata
);

    localparam int unsigned WIDTH_B  = WIDTH_A / RATIO;
    localparam int unsigned SEL_W    = mar_pkg::sel_bits(RATIO);
    localparam int unsigned SEL_WC   = (SEL_W == 0) ? 1 : SEL_W;
    localparam int unsigned ADDR_A_W = $clog2(DEPTH_A);
    localparam int unsigned ADDR_B_W = ADDR_A_W + SEL_W;

    logic [ADDR_A_W-1:0] b_word;
    logic [SEL_WC-1:0]   b_sel;
    assign b_word = ADDR_A_W'(b_addr >> SEL_W);
    assign b_sel  = SEL_WC'(b_addr & ADDR_B_W'(RATIO - 1));

    // Previous-cycle write records for each port.
    logic                wa_v, wb_v;
    logic [ADDR_A_W-1:0] wa_addr, wb_word;
    logic [WIDTH_A-1:0]  wa_data;
    logic [SEL_WC-1:0]   wb_sel;
    logic [WIDTH_B-1:0]  wb_data;
    logic [WIDTH_B-1:0]  exp_b_q;
    logic [SEL_WC-1:0]   exp_sel_q;
    logic [WIDTH_B-1:0]  exp_nar_q;
    logic [WIDTH_B-1:0]  a_slice;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_v <= 1'b0;
            wb_v <= 1'b0;
        end else begin
            wa_v <= a_en && a_we;
            wb_v <= b_en && b_we;
        end
        wa_addr   <= a_addr;
        wa_data   <= a_wdata;
        wb_word   <= b_word;
        wb_sel    <= b_sel;
        wb_data   <= b_wdata;
        exp_b_q   <= wa_data[int'(b_sel)*WIDTH_B +: WIDTH_B];
        exp_sel_q <= wb_sel;
        exp_nar_q <= wb_data;
    end

    always_comb begin
        a_slice = a_rdata[int'(exp_sel_q)*WIDTH_B +: WIDTH_B];
    end

    // R9
    a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_rdata));

    // R9
    b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));

    // R3
    a_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && wa_v && (a_addr == wa_addr) && !wb_v)
        |=> (a_rdata == $past(wa_data)));

    // R7
    a_to_b_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_we && wa_v && (b_word == wa_addr) && !wb_v)
        |=> (b_rdata == exp_b_q));

    // R5
    b_to_a_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && wb_v && (a_addr == wb_word) && !wa_v)
        |=> (a_slice == exp_nar_q));

endmodule

bind mixed_aspect_ram mar_checker #(
    .WIDTH_A (WIDTH_A),
    .DEPTH_A (DEPTH_A),
    .RATIO   (RATIO)
) u_mar_checker (.*);

// File: tb/test_mixed_aspect_ram.sv
module test_mixed_aspect_ram;

    localparam int CLK_PERIOD = 10;
    localparam int WA  = 8;
    localparam int DA  = 8;
    localparam int RT  = 4;
    localparam int WB  = WA / RT;
    localparam int AAW = 3;
    localparam int ABW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           a_en = 1'b0, a_we = 1'b0;
    logic [AAW-1:0] a_addr = '0;
    logic [WA-1:0]  a_wdata = '0;
    logic [WA-1:0]  a_rdata;
    logic           b_en = 1'b0, b_we = 1'b0;
    logic [ABW-1:0] b_addr = '0;
    logic [WB-1:0]  b_wdata = '0;
    logic [WB-1:0]  b_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixed_aspect_ram #(.WIDTH_A(WA), .DEPTH_A(DA), .RATIO(RT)) i_mixed_aspect_ram (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    int checks = 0;
    int failures = 0;
    logic [WA-1:0] model [DA];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
    endtask

    function automatic logic [WA-1:0] pat1(input int w);
        return WA'((w * 29 + 7) & 8'hFF);
    endfunction

    function automatic logic [WA-1:0] pat2(input int w);
        return WA'((w * 53 + 154) & 8'hFF);
    endfunction

    function automatic logic [WB-1:0] slice_of(input logic [WA-1:0] word, input int s);
        return WB'((word >> (s * WB)) & 3);
    endfunction

    function automatic logic [WA-1:0] put_slice(input logic [WA-1:0] word, input int s,
                                                input logic [WB-1:0] v);
        logic [WA-1:0] m;
        m = WA'(3) << (s * WB);
        return (word & ~m) | (WA'(v) << (s * WB));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [WB-1:0] held_b;
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        check("R10 reset a_rdata", 32'(a_rdata), 0);
        check("R10 reset b_rdata", 32'(b_rdata), 0);
        rst_n = 1'b1;

        check("R1 port B width", $bits(b_rdata), 2);
        check("R1 port B address width", $bits(b_addr), 5);

        // Fill through port A.
        for (int w = 0; w < DA; w++) begin
            a_en = 1'b1; a_we = 1'b1; a_addr = AAW'(w); a_wdata = pat1(w);
            tick();
            model[w] = pat1(w);
        end
        // Overwrite, checking read-first data.
        for (int w = 0; w < DA; w++) begin
            a_en = 1'b1; a_we = 1'b1; a_addr = AAW'(w); a_wdata = pat2(w);
            tick();
            check("R6 port A read-first", 32'(a_rdata), 32'(model[w]));
            model[w] = pat2(w);
        end
        // Read back through port A.
        for (int w = DA - 1; w >= 0; w--) begin
            a_en = 1'b1; a_we = 1'b0; a_addr = AAW'(w);
            tick();
            check("R2/R3 port A readback", 32'(a_rdata), 32'(model[w]));
        end
        idle();
        // Narrow read sweep of every slice.
        for (int n = 0; n < DA * RT; n++) begin
            b_en = 1'b1; b_we = 1'b0; b_addr = ABW'(n);
            tick();
            check("R4/R7 port B slice read", 32'(b_rdata), 32'(slice_of(model[n / RT], n % RT)));
        end
        // Narrow write sweep, checking read-first data.
        for (int n = 0; n < DA * RT; n++) begin
            logic [WB-1:0] v;
            v = WB'((n * 3 + 1) % 4);
            b_en = 1'b1; b_we = 1'b1; b_addr = ABW'(n); b_wdata = v;
            tick();
            check("R6 port B read-first", 32'(b_rdata), 32'(slice_of(model[n / RT], n % RT)));
            model[n / RT] = put_slice(model[n / RT], n % RT, v);
        end
        idle();
        // Wide read of merged words.
        for (int w = 0; w < DA; w++) begin
            a_en = 1'b1; a_we = 1'b0; a_addr = AAW'(w);
            tick();
            check("R5 merged word", 32'(a_rdata), 32'(model[w]));
        end
        // Enable low: writes ignored, read data held.
        a_en = 1'b1; a_we = 1'b0; a_addr = 3'd2;
        tick();
        a_en = 1'b0; a_we = 1'b1; a_addr = 3'd2; a_wdata = ~model[2];
        tick();
        check("R9 a_rdata held", 32'(a_rdata), 32'(model[2]));
        idle();
        b_en = 1'b1; b_we = 1'b0; b_addr = 5'd9;
        tick();
        held_b = b_rdata;
        b_en = 1'b0; b_we = 1'b1; b_addr = 5'd9; b_wdata = ~slice_of(model[2], 1);
        a_en = 1'b0; a_we = 1'b0;
        tick();
        check("R9 b_rdata held", 32'(b_rdata), 32'(held_b));
        idle();
        a_en = 1'b1; a_we = 1'b0; a_addr = 3'd2;
        tick();
        check("R9 memory unchanged", 32'(a_rdata), 32'(model[2]));
        idle();
        // Same-word collision.
        a_en = 1'b1; a_we = 1'b1; a_addr = 3'd5; a_wdata = 8'h3C;
        b_en = 1'b1; b_we = 1'b1; b_addr = 5'd22; b_wdata = 2'b01;
        tick();
        check("R8 collision a_rdata old", 32'(a_rdata), 32'(model[5]));
        check("R8 collision b_rdata old", 32'(b_rdata), 32'(slice_of(model[5], 2)));
        model[5] = put_slice(8'h3C, 2, 2'b01);
        idle();
        a_en = 1'b1; a_we = 1'b0; a_addr = 3'd5;
        tick();
        check("R8 collision merge", 32'(a_rdata), 32'(model[5]));
        idle();
        // Mid-run reset.
        rst_n = 1'b0;
        tick();
        check("R10 mid reset a_rdata", 32'(a_rdata), 0);
        check("R10 mid reset b_rdata", 32'(b_rdata), 0);
        rst_n = 1'b1;
        a_en = 1'b1; a_addr = 3'd5;
        b_en = 1'b1; b_addr = 5'd22;
        tick();
        check("R10 contents kept A", 32'(a_rdata), 32'(model[5]));
        check("R10 contents kept B", 32'(b_rdata), 32'(slice_of(model[5], 2)));
        idle();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule